// File: doc/BRIEF.md
# UART Receive Queue with Trigger Pulses

This block is the receive-side data queue of a serial port. Each entry is 12 bits wide: a character in bits [7:0] and four error flags above it, with framing in bit 8, parity in bit 9, break in bit 10 and overrun in bit 11. Entries come from the line receiver or from a loopback path on `push_valid`/`push_data`. A detected line break arrives on `brk_event` and is queued as an entry with only bit 10 set. The processor removes the oldest entry with a one-cycle `pop` strobe, which stands for a read of the data register. The head entry is always visible on `pop_data`.

The `fifo_en` input sets the usable depth. When it is high the queue holds `FIFO_DEPTH` entries (16 by default). When it is low the queue is a single holding register. Any change of `fifo_en` flushes the queue. The block registers its empty and full flags, a can-receive signal, and a one-cycle set pulse and clear pulse for the raw receive interrupt, with the trigger level fixed at one entry. It also keeps a 4-bit receive status. Every pop loads the popped entry's error nibble into this status.

Top module: `uart_rx_queue`

## Requirements
- R1: After reset: `rx_empty`=1, `rx_full`=0, `can_rx`=1, both interrupt pulses 0, `rx_status`=0, and the depth is one entry.
- R2: The depth is `FIFO_DEPTH` while the registered mode is enabled and 1 while it is disabled. `rx_full` rises when the count reaches the depth. `can_rx` is high exactly while the count is below the depth.
- R3: Entries leave in arrival order. `pop_data` shows the oldest entry while the queue is not empty.
- R4: A pop removes the head entry when the queue is not empty. A pop on an empty queue leaves the count at zero and `rx_empty` high.
- R5: Every pop loads bits [11:8] of the head entry into `rx_status`. Status bit 0 is framing, bit 1 parity, bit 2 break and bit 3 overrun. The new value is visible after the same clock edge.
- R6: `rx_int_set` pulses for one cycle after an accepted push that leaves the count equal to the trigger level (1).
- R7: `rx_int_clr` pulses for one cycle after any pop that leaves the count one below the trigger level, that is, zero. This includes a pop on an empty queue.
- R8: When a pop and a push share a cycle, the pop is applied first. The push is accepted if there is room after the pop, and both pulses may fire together.
- R9: A push with no room is dropped. The queued data is unchanged and `rx_status` bit 3 is set.
- R10: `brk_event` queues the entry 12'h400 and takes priority over `push_valid` in the same cycle. While the queue is in single-entry mode, it also sets `rx_status` bit 2.
- R11: A cycle in which `fifo_en` differs from the registered mode flushes the queue (empty, not full, count 0). Pops and pushes in that cycle are ignored and `rx_status` is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | 1: deep queue, 0: single holding register |
| push_valid | input | 1 | Push `push_data` this cycle |
| push_data | input | 12 | Entry: character [7:0], error flags [11:8] |
| brk_event | input | 1 | Line break seen; queue a break entry |
| pop | input | 1 | Data register read strobe |
| pop_data | output | 12 | Head entry |
| rx_empty | output | 1 | Queue empty |
| rx_full | output | 1 | Count equals current depth |
| can_rx | output | 1 | Room for another entry |
| rx_int_set | output | 1 | Set pulse for the raw receive interrupt |
| rx_int_clr | output | 1 | Clear pulse for the raw receive interrupt |
| rx_status | output | 4 | Error nibble latched on pop, plus overrun and break marks |

## Verification
The properties assume that the inputs change only between clock edges. Several of them hold only in cycles where `fifo_en` equals the mode seen on the previous cycle, so they avoid the flush cycle. The status-load and empty-pop properties also assume that no push or break arrives alongside the pop. The stimulus drives every input on the falling edge. Cycles that combine a pop with a push, a break or a mode change are listed explicitly in the vector table, so the checks on those cycles come from the bench.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;
    localparam int ENTRY_W = 12;
    localparam int CHAR_W  = 8;
    localparam int STS_W   = ENTRY_W - CHAR_W;
    localparam int BRK_BIT = 10;
    localparam int STS_BRK = BRK_BIT - CHAR_W;
    localparam int STS_OVR = 3;

    typedef logic [ENTRY_W-1:0] entry_t;
    typedef logic [STS_W-1:0]   status_t;

    localparam entry_t BRK_ENTRY = entry_t'(1) << BRK_BIT;
endpackage

// File: rtl/rxq_store.sv
module rxq_store
    import uart_rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_idx,
    input  entry_t           wr_data,
    input  logic [PTR_W-1:0] rd_idx,
    output entry_t           rd_data
);
    entry_t slot_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else if (wr_en && (wr_idx == PTR_W'(g))) begin
                slot_q[g] <= wr_data;
            end
        end
    end

    assign rd_data = slot_q[rd_idx];
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
    import uart_rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int TRIG  = 1,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic             push_valid,
    input  entry_t           push_data,
    input  logic             brk_event,
    input  logic             pop,
    input  status_t          head_flags,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_idx,
    output entry_t           wr_data,
    output logic [PTR_W-1:0] rd_idx,
    output logic             empty,
    output logic             full,
    output logic             can_rx,
    output logic             int_set,
    output logic             int_clr,
    output status_t          status
);
    typedef struct packed {
        logic             mode;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
        logic             empty;
        logic             full;
        logic             set;
        logic             clr;
        status_t          sts;
    } state_t;

    localparam state_t RST_STATE = '{
        mode: 1'b0, rd: '0, cnt: '0, empty: 1'b1, full: 1'b0,
        set: 1'b0, clr: 1'b0, sts: '0
    };

    state_t s_q, s_d;
    logic [CNT_W-1:0] depth_cur;
    logic [PTR_W-1:0] mask;
    logic [CNT_W-1:0] cnt_a;
    logic [PTR_W-1:0] rd_a;

    assign depth_cur = s_q.mode ? CNT_W'(DEPTH) : CNT_W'(1);
    assign mask      = s_q.mode ? PTR_W'(DEPTH - 1) : '0;

    always_comb begin
        s_d     = s_q;
        s_d.set = 1'b0;
        s_d.clr = 1'b0;
        wr_en   = 1'b0;
        wr_idx  = '0;
        wr_data = brk_event ? BRK_ENTRY : push_data;
        cnt_a   = s_q.cnt;
        rd_a    = s_q.rd;
        if (fifo_en != s_q.mode) begin
            // mode change flushes; traffic this cycle is ignored
            s_d.mode  = fifo_en;
            s_d.rd    = '0;
            s_d.cnt   = '0;
            s_d.empty = 1'b1;
            s_d.full  = 1'b0;
        end else begin
            if (pop) begin
                s_d.sts = head_flags;
                if (s_q.cnt != '0) begin
                    cnt_a = s_q.cnt - CNT_W'(1);
                    rd_a  = (s_q.rd + PTR_W'(1)) & mask;
                end
                s_d.clr = ((cnt_a + CNT_W'(1)) == CNT_W'(TRIG));
            end
            if (push_valid || brk_event) begin
                if (cnt_a < depth_cur) begin
                    wr_en   = 1'b1;
                    wr_idx  = (rd_a + cnt_a[PTR_W-1:0]) & mask;
                    cnt_a   = cnt_a + CNT_W'(1);
                    s_d.set = (cnt_a == CNT_W'(TRIG));
                end else begin
                    s_d.sts[STS_OVR] = 1'b1;
                end
                if (brk_event && !s_q.mode) begin
                    s_d.sts[STS_BRK] = 1'b1;
                end
            end
            s_d.rd    = rd_a;
            s_d.cnt   = cnt_a;
            s_d.empty = (cnt_a == '0);
            s_d.full  = (cnt_a == depth_cur);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= RST_STATE;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_idx  = s_q.rd;
    assign empty   = s_q.empty;
    assign full    = s_q.full;
    assign can_rx  = (s_q.cnt < depth_cur);
    assign int_set = s_q.set;
    assign int_clr = s_q.clr;
    assign status  = s_q.sts;
endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue
    import uart_rxq_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int TRIG_LEVEL = 1,
    localparam int PTR_W = $clog2(FIFO_DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fifo_en,
    input  logic               push_valid,
    input  logic [ENTRY_W-1:0] push_data,
    input  logic               brk_event,
    input  logic               pop,
    output logic [ENTRY_W-1:0] pop_data,
    output logic               rx_empty,
    output logic               rx_full,
    output logic               can_rx,
    output logic               rx_int_set,
    output logic               rx_int_clr,
    output logic [STS_W-1:0]   rx_status
);
    logic             wr_en;
    logic [PTR_W-1:0] wr_idx;
    logic [PTR_W-1:0] rd_idx;
    entry_t           wr_data;
    entry_t           head;

    rxq_ctrl #(.DEPTH(FIFO_DEPTH), .TRIG(TRIG_LEVEL)) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_en    (fifo_en),
        .push_valid (push_valid),
        .push_data  (push_data),
        .brk_event  (brk_event),
        .pop        (pop),
        .head_flags (head[ENTRY_W-1:CHAR_W]),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data),
        .rd_idx     (rd_idx),
        .empty      (rx_empty),
        .full       (rx_full),
        .can_rx     (can_rx),
        .int_set    (rx_int_set),
        .int_clr    (rx_int_clr),
        .status     (rx_status)
    );

    rxq_store #(.DEPTH(FIFO_DEPTH)) store_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (rd_idx),
        .rd_data (head)
    );

    assign pop_data = head;
endmodule

// File: rtl/uart_rx_queue_chk.sv
module uart_rx_queue_chk
    import uart_rxq_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               fifo_en,
    input logic               push_valid,
    input logic [ENTRY_W-1:0] push_data,
    input logic               brk_event,
    input logic               pop,
    input logic [ENTRY_W-1:0] pop_data,
    input logic               rx_empty,
    input logic               rx_full,
    input logic               can_rx,
    input logic               rx_int_set,
    input logic               rx_int_clr,
    input logic [STS_W-1:0]   rx_status
);
    logic prev_en;
    logic en_same;
    logic unused_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_en <= 1'b0;
        else        prev_en <= fifo_en;
    end

    assign en_same   = (fifo_en == prev_en);
    assign unused_ok = ^{push_data, pop_data[CHAR_W-1:0]};

    AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_empty && rx_full)); // R2
    AST_FULL_NO_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full |-> !can_rx); // R2
    AST_EMPTY_POP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (en_same && rx_empty && pop && !push_valid && !brk_event)
        |=> (rx_empty && rx_int_clr)); // R4
    AST_STATUS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (en_same && pop && !push_valid && !brk_event)
        |=> (rx_status == $past(pop_data[ENTRY_W-1:CHAR_W]))); // R5
    AST_FIRST_PUSH_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (en_same && rx_empty && (push_valid || brk_event)) |=> rx_int_set); // R6
    AST_OVERRUN_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        (en_same && rx_full && !pop && push_valid)
        |=> (rx_full && rx_status[STS_OVR])); // R9
    AST_MODE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en != prev_en) |=> (rx_empty && !rx_full)); // R11
endmodule

bind uart_rx_queue uart_rx_queue_chk chk_i (.*);

// File: tb/uart_rx_queue_tb_top.sv
module uart_rx_queue_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fifo_en = 1'b0;
    logic        push_valid = 1'b0;
    logic [11:0] push_data = '0;
    logic        brk_event = 1'b0;
    logic        pop = 1'b0;
    logic [11:0] pop_data;
    logic        rx_empty, rx_full, can_rx, rx_int_set, rx_int_clr;
    logic [3:0]  rx_status;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    uart_rx_queue dut_i (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .push_valid(push_valid),
        .push_data(push_data), .brk_event(brk_event), .pop(pop),
        .pop_data(pop_data), .rx_empty(rx_empty), .rx_full(rx_full),
        .can_rx(can_rx), .rx_int_set(rx_int_set), .rx_int_clr(rx_int_clr),
        .rx_status(rx_status)
    );

    typedef struct packed {
        logic        en, push, brk, pp;
        logic [11:0] din;
        logic        e_empty, e_full, e_can, e_set, e_clr;
        logic [3:0]  e_sts;
        logic [11:0] e_head;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t TBL [NV] = '{
        '{1,0,0,0,12'h000, 1,0,1,0,0, 4'h0, 12'h000, 11}, // enable: flush
        '{1,1,0,0,12'h041, 0,0,1,1,0, 4'h0, 12'h041, 6},  // first push sets
        '{1,1,0,0,12'h142, 0,0,1,0,0, 4'h0, 12'h041, 3},  // order kept
        '{1,0,0,1,12'h000, 0,0,1,0,0, 4'h0, 12'h142, 5},
        '{1,0,0,1,12'h000, 1,0,1,0,1, 4'h1, 12'h000, 7},  // last pop clears
        '{1,0,0,1,12'h000, 1,0,1,0,1, 4'h0, 12'h000, 4},  // pop on empty
        '{1,1,0,1,12'h255, 0,0,1,1,1, 4'h0, 12'h255, 8},  // pop+push on empty
        '{1,0,1,0,12'h000, 0,0,1,0,0, 4'h0, 12'h255, 10}, // break, deep mode
        '{1,0,0,1,12'h000, 0,0,1,0,0, 4'h2, 12'h400, 5},
        '{0,0,0,0,12'h000, 1,0,1,0,0, 4'h2, 12'h000, 11}, // disable: flush
        '{0,0,1,0,12'h000, 0,1,0,1,0, 4'h6, 12'h400, 10}, // break, single mode
        '{0,1,0,0,12'h0AA, 0,1,0,0,0, 4'hE, 12'h400, 9},  // dropped push
        '{0,1,0,1,12'h033, 0,1,0,1,1, 4'h4, 12'h033, 8},  // pop then push
        '{0,0,0,1,12'h000, 1,0,1,0,1, 4'h0, 12'h000, 7}
    };

    function automatic string req_name(int r);
        case (r)
            1: return "R1";   2: return "R2";   3: return "R3";
            4: return "R4";   5: return "R5";   6: return "R6";
            7: return "R7";   8: return "R8";   9: return "R9";
            10: return "R10"; 11: return "R11";
            default: return "R?";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step(input logic en, input logic pu, input logic bk,
                        input logic pp, input logic [11:0] d);
        fifo_en = en; push_valid = pu; brk_event = bk; pop = pp; push_data = d;
        @(posedge clk);
        @(negedge clk);
        push_valid = 1'b0; brk_event = 1'b0; pop = 1'b0;
    endtask

    function automatic logic [11:0] ent(int i);
        return {2'b00, 1'(i % 2), 1'b0, 8'(i * 7 + 3)};
    endfunction

    task automatic check_reset_state();
        chk({rx_empty, rx_full, can_rx, rx_int_set, rx_int_clr, rx_status} == 9'b101000000,
            "R1", "reset flags {empty,full,can,set,clr,sts}",
            32'({rx_empty, rx_full, can_rx, rx_int_set, rx_int_clr, rx_status}),
            32'(9'b101000000));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check_reset_state(); // R1
        rst_n = 1'b1;
        @(negedge clk);
        check_reset_state(); // R1

        // vector table
        for (int v = 0; v < NV; v++) begin
            logic [8:0] act_f, exp_f;
            step(TBL[v].en, TBL[v].push, TBL[v].brk, TBL[v].pp, TBL[v].din);
            act_f = {rx_empty, rx_full, can_rx, rx_int_set, rx_int_clr, rx_status};
            exp_f = {TBL[v].e_empty, TBL[v].e_full, TBL[v].e_can, TBL[v].e_set,
                     TBL[v].e_clr, TBL[v].e_sts};
            chk(act_f == exp_f, req_name(int'(TBL[v].req)),
                $sformatf("row %0d flags", v), 32'(act_f), 32'(exp_f));
            if (!TBL[v].e_empty)
                chk(pop_data == TBL[v].e_head, req_name(int'(TBL[v].req)),
                    $sformatf("row %0d head", v), 32'(pop_data), 32'(TBL[v].e_head));
        end

        // R2 R6: fill the deep queue
        step(1'b1, 1'b0, 1'b0, 1'b0, '0);
        for (int i = 0; i < 16; i++) begin
            step(1'b1, 1'b1, 1'b0, 1'b0, ent(i));
            chk(rx_full == (i == 15), "R2", $sformatf("full after push %0d", i),
                32'(rx_full), 32'(i == 15));
            chk(can_rx == (i != 15), "R2", $sformatf("can_rx after push %0d", i),
                32'(can_rx), 32'(i != 15));
            chk(rx_int_set == (i == 0), "R6", $sformatf("set after push %0d", i),
                32'(rx_int_set), 32'(i == 0));
        end
        // R9: overflow push dropped
        step(1'b1, 1'b1, 1'b0, 1'b0, 12'hFFF);
        chk(rx_full && rx_status[3], "R9", "overrun mark while full",
            32'({rx_full, rx_status[3]}), 32'h3);
        chk(pop_data == ent(0), "R9", "head unchanged by dropped push",
            32'(pop_data), 32'(ent(0)));
        // R3 R5 R7: drain in order
        for (int i = 0; i < 16; i++) begin
            chk(pop_data == ent(i), "R3", $sformatf("head before pop %0d", i),
                32'(pop_data), 32'(ent(i)));
            step(1'b1, 1'b0, 1'b0, 1'b1, '0);
            chk(rx_status == ent(i)[11:8], "R5", $sformatf("status after pop %0d", i),
                32'(rx_status), 32'(ent(i)[11:8]));
            chk(rx_int_clr == (i == 15), "R7", $sformatf("clr after pop %0d", i),
                32'(rx_int_clr), 32'(i == 15));
        end
        chk(rx_empty && !rx_full, "R4", "empty after drain",
            32'({rx_empty, rx_full}), 32'h2);

        // R11: mode change while holding data
        step(1'b1, 1'b1, 1'b0, 1'b0, 12'h011);
        step(1'b1, 1'b1, 1'b0, 1'b0, 12'h022);
        step(1'b0, 1'b1, 1'b0, 1'b0, 12'h033);
        chk(rx_empty && !rx_full && !rx_int_set, "R11", "flush ignores push",
            32'({rx_empty, rx_full, rx_int_set}), 32'h4);

        // R10: break wins over data in the same cycle
        step(1'b0, 1'b1, 1'b1, 1'b0, 12'h0CC);
        chk(pop_data == 12'h400 && rx_status[2], "R10", "break priority",
            32'({rx_status[2], pop_data}), 32'h1400);

        // R1: reset while holding data
        rst_n = 1'b0;
        @(negedge clk);
        check_reset_state(); // R1
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule